// File: doc/BRIEF.md
# Prioritized Nested Interrupt Controller

This block collects fourteen interrupt sources and presents one of them to a processor as a vector index. Seven sources arrive on asynchronous pins: a power-hold pin and six general interrupt pins. Each pin passes through a two-flop synchroniser and then an edge detector. Six of the pins can be set to trigger on a rising or a falling edge. The power-hold pin reacts to falling edges only. The other seven sources are synchronous request strobes: three from serial ports and four from timers. A request is latched as pending only while that source's enable flag is set. A pending request is offered to the processor only while its enable flag is set.

A fixed priority chain picks one candidate from the enabled pending sources. A nesting stack records the priority of every handler that is still running. A candidate is offered only if its priority is strictly higher than the one on top of the stack and the stack has room. On an acknowledge, the granted source's pending flag is cleared and its vector is pushed. On a return, the top entry is popped. When the stack is full, new requests stay pending until a return frees a level.

Top module: `irq_nest_ctrl`

## Requirements
- R1: After reset, `irq_valid` is 0, `irq_vec` is 0, `nest_depth` is 0 and no source is pending.
- R2: Vector numbering sets the priority, and a lower number always wins. Vector 0 is the power-hold pin (`ext_pin[0]`). Vectors 1 to 6 are `ext_pin[1..6]`. Vectors 7 to 13 are `int_req[0..6]`: serial ports 0 to 2, then timers 0 to 3. `irq_vec` shows the lowest-numbered enabled pending source.
- R3: For pin k in 1..6, `trig_rise[k-1]` = 1 selects the rising edge and 0 selects the falling edge. An edge of the other direction is ignored.
- R4: `ext_pin[0]` latches a request on a falling edge only. A rising edge on it never sets a request.
- R5: A pin edge goes through two synchroniser flops and one pending flop. Counting from the pin change, `irq_valid` is still 0 after two clock edges and becomes 1 after the third edge.
- R6: A request that arrives while its `src_en` bit is 0 is dropped. A source that is already pending but whose `src_en` bit is 0 is not offered to the processor.
- R7: A one-cycle pulse on an `int_req` bit with its source enabled sets that source pending. The source is offered after the next clock edge.
- R8: `irq_ack` while `irq_valid` is 1 clears the granted source's pending flag and raises `nest_depth` by one. `irq_ack` while `irq_valid` is 0 has no effect.
- R9: While a handler is active, only a source with a strictly lower vector number than the top of the stack is offered. Sources of the same or lower priority wait.
- R10: `irq_ret` lowers `nest_depth` by one and restores the previous top of the stack as the preemption threshold. `irq_ret` at depth 0 has no effect.
- R11: When `nest_depth` equals NEST_DEPTH (16 by default), `irq_valid` stays 0 and requests stay pending. After a return, the waiting request is offered.
- R12: When an acknowledge and a return fall in the same cycle, `nest_depth` does not change. The granted vector becomes the new top of the stack, and the granted source's pending flag is cleared.
- R13: A new request on a source in the same cycle as that source's acknowledge leaves the source pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_pin | input | N_EXT | Asynchronous pins; bit 0 is the falling-only power-hold pin |
| trig_rise | input | N_EXT-1 | Edge select for pins 1 and up: 1 = rising, 0 = falling |
| int_req | input | N_INT | Synchronous request strobes from serial ports and timers |
| src_en | input | N_EXT+N_INT | Per-vector enable flags |
| irq_ack | input | 1 | Processor accepts the offered vector |
| irq_ret | input | 1 | Processor leaves the current handler |
| irq_valid | output | 1 | A vector is being offered |
| irq_vec | output | clog2(N_EXT+N_INT) | Offered vector, 0 when none is offered |
| nest_depth | output | clog2(NEST_DEPTH+1) | Number of active nested handlers |

## Verification
Two pairs of events can land on the same clock edge. An acknowledge can coincide with a return. A fresh request on a source can coincide with the acknowledge that clears that source's pending flag. The bench drives `irq_ack` together with `irq_ret`, and checks three things: the depth does not move, the acknowledged request is gone, and the swapped-in vector acts as the new threshold (a lower-priority request that arrives afterwards is held back). The bench also drives a request pulse in the very cycle of its own acknowledge. It then checks that the source is offered again once the handler returns.

// File: rtl/irq_pkg.sv
package irq_pkg;

   // Stack operation encoded as {push, pop}
   typedef enum logic [1:0] {
      STK_HOLD = 2'b00,
      STK_POP  = 2'b01,
      STK_PUSH = 2'b10,
      STK_SWAP = 2'b11
   } stk_op_e;

endpackage

// File: rtl/irq_edge_det.sv
module irq_edge_det #(
   parameter int STAGES = 2,
   parameter bit IDLE   = 1'b1
)(
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   input  logic rise_sel,
   output logic edge_hit
);

   logic [STAGES-1:0] sync_q;
   logic              last_q;
   logic              cur;

   if (STAGES < 2) begin : g_bad_stages
      $error("irq_edge_det: STAGES must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= {STAGES{IDLE}};
         last_q <= IDLE;
      end else begin
         sync_q <= {sync_q[STAGES-2:0], pin};
         last_q <= sync_q[STAGES-1];
      end
   end

   assign cur      = sync_q[STAGES-1];
   assign edge_hit = rise_sel ? (cur & ~last_q) : (~cur & last_q);

endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
   parameter int N = 14,
   parameter int W = $clog2(N)
)(
   input  logic [N-1:0] req,
   output logic         found,
   output logic [W-1:0] idx
);

   if (N < 2) begin : g_bad_n
      $error("irq_prio_enc: N must be at least 2");
   end

   // Lowest index has the highest priority
   always_comb begin
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) idx = W'(i);
      end
   end

   assign found = |req;

endmodule

// File: rtl/irq_nest_stack.sv
module irq_nest_stack
   import irq_pkg::*;
#(
   parameter int DEPTH = 16,
   parameter int W     = 4,
   parameter int DW    = $clog2(DEPTH + 1)
)(
   input  logic          clk,
   input  logic          rst_n,
   input  stk_op_e       op,
   input  logic [W-1:0]  din,
   output logic [W-1:0]  top,
   output logic          empty,
   output logic          full,
   output logic [DW-1:0] depth
);

   localparam int AW = $clog2(DEPTH);
   localparam logic [DW-1:0] FULL_CNT = DW'(DEPTH);

   if (DEPTH < 2) begin : g_bad_depth
      $error("irq_nest_stack: DEPTH must be at least 2");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [DW-1:0] cnt;
   logic [AW-1:0] ptr_top;
   logic [AW-1:0] ptr_nxt;
   logic          do_push;
   logic          do_pop;

   assign empty   = (cnt == '0);
   assign full    = (cnt == FULL_CNT);
   assign ptr_top = AW'(cnt - 1'b1);
   assign ptr_nxt = AW'(cnt);
   assign do_push = (op == STK_PUSH) && !full;
   assign do_pop  = (op == STK_POP) && !empty;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt <= '0;
      else if (do_push) cnt <= cnt + 1'b1;
      else if (do_pop)  cnt <= cnt - 1'b1;
   end

   always_ff @(posedge clk) begin
      if (do_push)                        mem[ptr_nxt] <= din;
      else if (op == STK_SWAP && !empty)  mem[ptr_top] <= din;
   end

   assign top   = empty ? '0 : mem[ptr_top];
   assign depth = cnt;

endmodule

// File: rtl/irq_nest_ctrl.sv
module irq_nest_ctrl
   import irq_pkg::*;
#(
   parameter int N_EXT       = 7,
   parameter int N_INT       = 7,
   parameter int NEST_DEPTH  = 16,
   parameter int SYNC_STAGES = 2,
   parameter bit PIN_IDLE    = 1'b1
)(
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic [N_EXT-1:0]                    ext_pin,
   input  logic [N_EXT-2:0]                    trig_rise,
   input  logic [N_INT-1:0]                    int_req,
   input  logic [N_EXT+N_INT-1:0]              src_en,
   input  logic                                irq_ack,
   input  logic                                irq_ret,
   output logic                                irq_valid,
   output logic [$clog2(N_EXT+N_INT)-1:0]      irq_vec,
   output logic [$clog2(NEST_DEPTH+1)-1:0]     nest_depth
);

   localparam int N_SRC = N_EXT + N_INT;
   localparam int VEC_W = $clog2(N_SRC);
   localparam int DEP_W = $clog2(NEST_DEPTH + 1);

   if (N_EXT < 2) begin : g_bad_ext
      $error("irq_nest_ctrl: N_EXT must be at least 2");
   end
   if (N_INT < 1) begin : g_bad_int
      $error("irq_nest_ctrl: N_INT must be at least 1");
   end

   logic [N_EXT-1:0] ext_hit;
   logic [N_SRC-1:0] pend_q;
   logic [N_SRC-1:0] set_vec;
   logic [N_SRC-1:0] clr_vec;
   logic [N_SRC-1:0] cand;
   logic             cand_found;
   logic [VEC_W-1:0] cand_idx;
   logic [VEC_W-1:0] top_idx;
   logic             stk_empty;
   logic             stk_full;
   logic [DEP_W-1:0] stk_depth;
   logic             beats_top;
   logic             ack_take;
   logic             ret_take;
   stk_op_e          stk_op;

   // Edge detection per pin; pin 0 is tied to falling-edge mode
   for (genvar i = 0; i < N_EXT; i++) begin : g_ext
      logic rise_sel;
      if (i == 0) begin : g_hold
         assign rise_sel = 1'b0;
      end else begin : g_pin
         assign rise_sel = trig_rise[i-1];
      end
      irq_edge_det #(
         .STAGES (SYNC_STAGES),
         .IDLE   (PIN_IDLE)
      ) u_det (
         .clk      (clk),
         .rst_n    (rst_n),
         .pin      (ext_pin[i]),
         .rise_sel (rise_sel),
         .edge_hit (ext_hit[i])
      );
   end

   assign set_vec = {int_req, ext_hit} & src_en;
   assign cand    = pend_q & src_en;

   irq_prio_enc #(
      .N (N_SRC),
      .W (VEC_W)
   ) u_enc (
      .req   (cand),
      .found (cand_found),
      .idx   (cand_idx)
   );

   assign beats_top = stk_empty || (cand_idx < top_idx);
   assign irq_valid = cand_found && beats_top && !stk_full;
   assign irq_vec   = irq_valid ? cand_idx : '0;

   assign ack_take = irq_ack && irq_valid;
   assign ret_take = irq_ret && !stk_empty;
   assign stk_op   = stk_op_e'({ack_take, ret_take});
   assign clr_vec  = ack_take ? (N_SRC'(1) << cand_idx) : '0;

   // A new request wins over the clear of the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q <= '0;
      else        pend_q <= (pend_q & ~clr_vec) | set_vec;
   end

   irq_nest_stack #(
      .DEPTH (NEST_DEPTH),
      .W     (VEC_W),
      .DW    (DEP_W)
   ) u_stk (
      .clk   (clk),
      .rst_n (rst_n),
      .op    (stk_op),
      .din   (cand_idx),
      .top   (top_idx),
      .empty (stk_empty),
      .full  (stk_full),
      .depth (stk_depth)
   );

   assign nest_depth = stk_depth;

endmodule

// File: rtl/irq_nest_ctrl_chk.sv
module irq_nest_ctrl_chk #(
   parameter int N_EXT      = 7,
   parameter int N_INT      = 7,
   parameter int NEST_DEPTH = 16
)(
   input logic                                clk,
   input logic                                rst_n,
   input logic [N_EXT+N_INT-1:0]              src_en,
   input logic                                irq_ack,
   input logic                                irq_ret,
   input logic                                irq_valid,
   input logic [$clog2(N_EXT+N_INT)-1:0]      irq_vec,
   input logic [$clog2(NEST_DEPTH+1)-1:0]     nest_depth
);

   localparam int DEP_W = $clog2(NEST_DEPTH + 1);
   localparam logic [DEP_W-1:0] FULL_LVL = DEP_W'(NEST_DEPTH);

   // R11
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      nest_depth <= FULL_LVL);

   // R11
   full_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (nest_depth == FULL_LVL) |-> !irq_valid);

   // R6
   masked_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_valid |-> src_en[irq_vec]);

   // R8
   push_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_ack && irq_valid && !irq_ret) |=> (nest_depth == $past(nest_depth) + 1'b1));

   // R10
   pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_ret && nest_depth != '0 && !(irq_ack && irq_valid))
      |=> (nest_depth == $past(nest_depth) - 1'b1));

   // R10
   ret_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_ret && nest_depth == '0 && !irq_ack) |=> (nest_depth == '0));

   // R12
   swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_ack && irq_valid && irq_ret) |=> $stable(nest_depth));

   // R9
   preempt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_ack && irq_valid && !irq_ret) |=> (!irq_valid || irq_vec < $past(irq_vec)));

endmodule

bind irq_nest_ctrl irq_nest_ctrl_chk #(
   .N_EXT      (N_EXT),
   .N_INT      (N_INT),
   .NEST_DEPTH (NEST_DEPTH)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .src_en     (src_en),
   .irq_ack    (irq_ack),
   .irq_ret    (irq_ret),
   .irq_valid  (irq_valid),
   .irq_vec    (irq_vec),
   .nest_depth (nest_depth)
);

// File: tb/irq_nest_ctrl_bench.sv
module irq_nest_ctrl_bench;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [6:0]  ext_pin;
   logic [5:0]  trig_rise;
   logic [6:0]  int_req;
   logic [13:0] src_en;
   logic        irq_ack;
   logic        irq_ret;
   logic        irq_valid;
   logic [3:0]  irq_vec;
   logic [4:0]  nest_depth;

   logic [6:0]  s_int_req;
   logic        s_ack;
   logic        s_ret;
   logic        s_valid;
   logic [3:0]  s_vec;
   logic [1:0]  s_depth;

   int checks   = 0;
   int failures = 0;
   bit done     = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   irq_nest_ctrl u_irq_nest_ctrl (
      .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .trig_rise(trig_rise),
      .int_req(int_req), .src_en(src_en), .irq_ack(irq_ack), .irq_ret(irq_ret),
      .irq_valid(irq_valid), .irq_vec(irq_vec), .nest_depth(nest_depth)
   );

   irq_nest_ctrl #(.NEST_DEPTH(2)) u_irq_nest_ctrl_small (
      .clk(clk), .rst_n(rst_n), .ext_pin(7'h7F), .trig_rise(6'h00),
      .int_req(s_int_req), .src_en(14'h3FFF), .irq_ack(s_ack), .irq_ret(s_ret),
      .irq_valid(s_valid), .irq_vec(s_vec), .nest_depth(s_depth)
   );

   // Table entry: {request pattern, internal enables, expected valid, expected vector}
   localparam logic [18:0] TBL [6] = '{
      {7'b0000001, 7'b1111111, 1'b1, 4'd7},
      {7'b1000000, 7'b1111111, 1'b1, 4'd13},
      {7'b0110000, 7'b1111111, 1'b1, 4'd11},
      {7'b1111111, 7'b1111110, 1'b1, 4'd8},
      {7'b0000100, 7'b1111011, 1'b0, 4'd0},
      {7'b1010000, 7'b0010000, 1'b1, 4'd11}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse_int(input int idx);
      int_req[idx] = 1'b1;
      tick(1);
      int_req = '0;
   endtask

   task automatic ack_once;
      irq_ack = 1'b1;
      tick(1);
      irq_ack = 1'b0;
   endtask

   task automatic ret_once;
      irq_ret = 1'b1;
      tick(1);
      irq_ret = 1'b0;
   endtask

   task automatic drain;
      for (int k = 0; k < 20 && irq_valid; k++) begin
         ack_once();
         ret_once();
      end
   endtask

   task automatic finish_run;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         failures++;
         $display("FAIL R1 watchdog actual=timeout expected=completion");
         finish_run();
      end
   end

   initial begin
      rst_n = 1'b0; ext_pin = 7'h7F; trig_rise = '0; int_req = '0;
      src_en = '1; irq_ack = 1'b0; irq_ret = 1'b0;
      s_int_req = '0; s_ack = 1'b0; s_ret = 1'b0;
      tick(3);
      rst_n = 1'b1;
      tick(1);
      // R1 reset state
      chk("R1 valid", irq_valid, 0);
      chk("R1 vec", irq_vec, 0);
      chk("R1 depth", nest_depth, 0);

      // R2 R7 table walk of internal sources
      for (int t = 0; t < 6; t++) begin
         src_en = {TBL[t][11:5], 7'h7F};
         int_req = TBL[t][18:12];
         tick(1);
         int_req = '0;
         chk("R2 R7 table valid", irq_valid, TBL[t][4]);
         chk("R2 R7 table vec", irq_vec, TBL[t][3:0]);
         src_en = '1;
         drain();
      end

      // R3 R5: pin 1 in rising mode, falling edge ignored, rising edge timed
      trig_rise[0] = 1'b1;
      ext_pin[1] = 1'b0;
      tick(4);
      chk("R3 falling ignored in rising mode", irq_valid, 0);
      ext_pin[1] = 1'b1;
      tick(2);
      chk("R5 not yet after two edges", irq_valid, 0);
      tick(1);
      chk("R5 valid after third edge", irq_valid, 1);
      chk("R2 pin1 vector", irq_vec, 1);
      drain();

      // R3: pin 2 in falling mode
      ext_pin[2] = 1'b0;
      tick(3);
      chk("R3 falling mode vec", irq_vec, 2);
      drain();
      ext_pin[2] = 1'b1;
      tick(4);
      chk("R3 rising ignored in falling mode", irq_valid, 0);

      // R4: hold pin falls only
      trig_rise = '1;
      ext_pin[0] = 1'b0;
      tick(3);
      chk("R4 hold falling vec", irq_vec, 0);
      chk("R4 hold falling valid", irq_valid, 1);
      drain();
      ext_pin[0] = 1'b1;
      tick(4);
      chk("R4 hold rising ignored", irq_valid, 0);
      trig_rise = '0;

      // R6: edge while disabled is dropped
      src_en[3] = 1'b0;
      ext_pin[3] = 1'b0;
      tick(4);
      chk("R6 disabled edge", irq_valid, 0);
      src_en[3] = 1'b1;
      #1;
      chk("R6 disabled edge not latched", irq_valid, 0);
      ext_pin[3] = 1'b1;
      tick(4);

      // R6 R7: pending source hidden while disabled
      pulse_int(0);
      chk("R7 pulse offered next cycle", irq_vec, 7);
      src_en[7] = 1'b0;
      #1;
      chk("R6 pending hidden", irq_valid, 0);
      src_en[7] = 1'b1;
      #1;
      chk("R6 pending shown again", irq_vec, 7);
      drain();

      // R8 R9 R10 nesting
      pulse_int(3);
      ack_once();
      chk("R8 depth after ack", nest_depth, 1);
      chk("R8 pending cleared", irq_valid, 0);
      ack_once();
      chk("R8 ack without valid ignored", nest_depth, 1);
      pulse_int(5);
      chk("R9 lower priority waits", irq_valid, 0);
      pulse_int(1);
      chk("R9 higher priority preempts", irq_vec, 8);
      ack_once();
      chk("R8 depth two", nest_depth, 2);
      ret_once();
      chk("R10 depth after return", nest_depth, 1);
      chk("R10 threshold restored", irq_valid, 0);
      ret_once();
      chk("R10 depth zero", nest_depth, 0);
      chk("R10 waiting source offered", irq_vec, 12);
      ack_once();
      ret_once();
      ret_once();
      chk("R10 return at depth zero ignored", nest_depth, 0);
      chk("R10 nothing left", irq_valid, 0);

      // R12 acknowledge and return together
      pulse_int(4);
      ack_once();
      pulse_int(2);
      chk("R12 preempting vec", irq_vec, 9);
      irq_ack = 1'b1; irq_ret = 1'b1;
      tick(1);
      irq_ack = 1'b0; irq_ret = 1'b0;
      chk("R12 depth unchanged", nest_depth, 1);
      chk("R12 granted cleared", irq_valid, 0);
      pulse_int(3);
      chk("R12 new top blocks vector 10", irq_valid, 0);
      ret_once();
      chk("R12 vector 10 after return", irq_vec, 10);
      drain();

      // R13 request in the cycle of its own acknowledge
      pulse_int(0);
      irq_ack = 1'b1; int_req[0] = 1'b1;
      tick(1);
      irq_ack = 1'b0; int_req = '0;
      chk("R13 depth after ack", nest_depth, 1);
      chk("R13 same source waits", irq_valid, 0);
      ret_once();
      chk("R13 source still pending", irq_vec, 7);
      drain();
      chk("R13 drained depth", nest_depth, 0);

      // R11 full stack on a two-level instance
      s_int_req[6] = 1'b1; tick(1); s_int_req = '0;
      s_ack = 1'b1; tick(1); s_ack = 1'b0;
      s_int_req[5] = 1'b1; tick(1); s_int_req = '0;
      s_ack = 1'b1; tick(1); s_ack = 1'b0;
      chk("R11 small depth full", s_depth, 2);
      s_int_req[0] = 1'b1; tick(1); s_int_req = '0;
      chk("R11 full blocks request", s_valid, 0);
      s_ack = 1'b1; tick(1); s_ack = 1'b0;
      chk("R11 ack at full ignored", s_depth, 2);
      s_ret = 1'b1; tick(1); s_ret = 1'b0;
      chk("R11 offered after return", s_vec, 7);
      chk("R11 depth after return", s_depth, 1);

      done = 1'b1;
      finish_run();
   end

endmodule